// File: doc/BRIEF.md
# Accumulator Machine Memory-Reference Executor

This block runs the memory-reference part of a small 16-bit accumulator machine. It holds an accumulator, a carry flag, a program counter, address and data registers, an instruction register, and a step counter. It also holds a word-addressed memory of its own. While `run` is high, the step counter moves through timing steps T0, T1 and onward. Each step enables one group of register transfers, chosen by the decoded opcode line and the current step. The last step of an instruction returns the counter to T0. Every instruction begins with a three-step fetch and one step of address resolution. It then executes AND, ADD, LDA, STA, BUN, BSA or ISZ in one to three further steps.

The memory is loaded through a side port only while `run` is low, and any word can be read back at any time. This lets a program be placed in memory, run, and its results inspected. The instruction word has these fields:

| Bits | Field | Meaning |
|------|-------|---------|
| 15 | I | 0 = direct, 1 = indirect |
| 14:12 | opcode | 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ, 7 outside this block |
| 11:0 | address | operand address |

The memory holds 2^MEM_AW words. An address selects a word by its low MEM_AW bits.

Top module: `acc_mref_core`

## Requirements
- R1: While `rst_n` is low, `ac`, `e`, `pc` and `sc` read zero and `done` is low.
- R2: With `run` low, a high `ld_we` writes `ld_wdata` to the word at `ld_addr`. With `run` high, `ld_we` is ignored. `rd_data` always shows the word at `rd_addr`.
- R3: The step counter advances on each clock only while `run` is high. With `run` low, `sc`, `pc`, `ac` and `e` hold their values.
- R4: The fetch occupies T0 to T2. In T1, `pc` increases by one. In T2, the address field and the I bit are latched.
- R5: AND (opcode 0) puts AC AND M[addr] into AC, and LDA (opcode 2) puts M[addr] into AC. Each takes 6 cycles.
- R6: ADD (opcode 1) puts the low 16 bits of AC+M[addr] into AC and the carry out into `e`, taking 6 cycles. No other instruction changes `e`.
- R7: STA (opcode 3) writes AC to M[addr] in 5 cycles.
- R8: BUN (opcode 4) loads `pc` with the address in 5 cycles.
- R9: BSA (opcode 5) writes the incremented `pc` to M[addr] and sets `pc` to addr+1, taking 6 cycles.
- R10: ISZ (opcode 6) writes M[addr]+1 back to memory in 7 cycles. When the result is zero, it adds one more to `pc`.
- R11: Opcode 7 finishes at T3 (4 cycles) and changes no register apart from the fetch's `pc` increment.
- R12: When I=1 (bit 15), the operand address is the low 12 bits of the word at the address field, read in T3.
- R13: `done` is high exactly in the final step of each instruction, and `sc` is 0 on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| run | input | 1 | step enable |
| ld_we | input | 1 | load-port write enable (honoured only when stopped) |
| ld_addr | input | 12 | load-port address |
| ld_wdata | input | 16 | load-port data |
| rd_addr | input | 12 | read-port address |
| rd_data | output | 16 | memory word at `rd_addr` |
| ac | output | 16 | accumulator |
| e | output | 1 | carry flag |
| pc | output | 12 | program counter |
| sc | output | 3 | current timing step |
| done | output | 1 | last step of the current instruction |

## Verification
The assertions assume three things about the inputs:
- `run` is raised only when the step counter is at T0 or resumes a paused instruction.
- The load port is used only while stopped.
- Opcode fields arrive through memory loaded before the run.

The stimulus respects all three. It writes every memory word while `run` is low and then raises `run` once at T0. It pulses `ld_we` during the run only to show that the pulse has no effect. It lowers `run` only to check that state holds.

// File: rtl/acc_mref_core.sv
module acc_mref_core #(
  parameter int AW     = 12,
  parameter int DW     = 16,
  parameter int MEM_AW = 8,
  parameter int SCW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ac,
  output logic          e,
  output logic [AW-1:0] pc,
  output logic [SCW-1:0] sc,
  output logic          done
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0]  mem [DEPTH];
  logic [DW-1:0]  dr, ir;
  logic [AW-1:0]  ar;
  logic           ind;
  logic [SCW-1:0] sc_q;

  wire [2:0]    op   = ir[DW-2:DW-4];
  wire [7:0]    d    = 8'd1 << op;
  wire [DW-1:0] m_ar = mem[ar[MEM_AW-1:0]];
  wire [DW:0]   sum  = {1'b0, ac} + {1'b0, dr};

  assign sc      = sc_q;
  assign rd_data = mem[rd_addr[MEM_AW-1:0]];

  assign done = run && ((sc_q == SCW'(3) && d[7]) ||
                        (sc_q == SCW'(4) && (d[3] | d[4])) ||
                        (sc_q == SCW'(5) && (d[0] | d[1] | d[2] | d[5])) ||
                        (sc_q == SCW'(6)));

  wire          mem_we = run ? ((sc_q == SCW'(4) && (d[3] | d[5])) ||
                                (sc_q == SCW'(6) && d[6])) : ld_we;
  wire [AW-1:0] mem_wa = run ? ar : ld_addr;
  wire [DW-1:0] mem_wd = !run ? ld_wdata :
                         d[3] ? ac :
                         d[5] ? {{(DW-AW){1'b0}}, pc} : dr;

  always_ff @(posedge clk)
    if (mem_we) mem[mem_wa[MEM_AW-1:0]] <= mem_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac <= '0; e <= 1'b0; pc <= '0; sc_q <= '0;
      ar <= '0; dr <= '0; ir <= '0; ind <= 1'b0;
    end else if (run) begin
      sc_q <= done ? '0 : sc_q + 1'b1;
      case (sc_q)
        SCW'(0): ar <= pc;
        SCW'(1): begin
          ir <= m_ar;
          pc <= pc + 1'b1;
        end
        SCW'(2): begin
          ar  <= ir[AW-1:0];
          ind <= ir[DW-1];
        end
        SCW'(3): if (ind && !d[7]) ar <= m_ar[AW-1:0];
        SCW'(4): begin
          if (d[0] | d[1] | d[2] | d[6]) dr <= m_ar;
          if (d[4]) pc <= ar;
          if (d[5]) ar <= ar + 1'b1;
        end
        SCW'(5): begin
          if (d[0]) ac <= ac & dr;
          if (d[1]) {e, ac} <= sum;
          if (d[2]) ac <= dr;
          if (d[5]) pc <= ar;
          if (d[6]) dr <= dr + 1'b1;
        end
        SCW'(6): if (dr == '0) pc <= pc + 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_mref_core_chk.sv
module acc_mref_core_chk #(
  parameter int AW  = 12,
  parameter int DW  = 16,
  parameter int SCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic           done,
  input logic [SCW-1:0] sc,
  input logic [DW-1:0]  ac,
  input logic           e,
  input logic [AW-1:0]  pc,
  input logic [2:0]     op
);
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(sc) && $stable(pc) && $stable(ac) && $stable(e)));

  a_r13_done_returns_t0: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (sc == '0));

  a_r13_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !done) |=> (sc == $past(sc) + 1'b1));

  a_r13_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sc <= SCW'(6));

  a_r4_pc_inc_t1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc == SCW'(1)) |=> (pc == $past(pc) + 1'b1));

  a_r11_op7_ends_t3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sc == SCW'(3) && op == 3'd7) |-> done);

  a_r6_e_only_add: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(e) |-> ($past(run) && $past(sc) == SCW'(5) && $past(op) == 3'd1));

  a_r10_pc_change_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> ($past(run) && ($past(sc) == SCW'(1) || $past(sc) == SCW'(4) ||
                                     $past(sc) == SCW'(5) || $past(sc) == SCW'(6))));
endmodule

bind acc_mref_core acc_mref_core_chk #(.AW(AW), .DW(DW), .SCW(SCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .done(done), .sc(sc),
  .ac(ac), .e(e), .pc(pc), .op(ir[DW-2:DW-4])
);

// File: tb/acc_mref_core_bench.sv
module acc_mref_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        ld_we = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_wdata = '0;
  logic [11:0] rd_addr = '0;
  logic [15:0] rd_data, ac;
  logic        e, done;
  logic [11:0] pc;
  logic [2:0]  sc;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  acc_mref_core u_acc_mref_core (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_wdata(ld_wdata), .rd_addr(rd_addr), .rd_data(rd_data), .ac(ac),
    .e(e), .pc(pc), .sc(sc), .done(done)
  );

  // {ac, e, pc, probe address, probe data, cycles}
  localparam logic [60:0] VEC [14] = '{
    {16'h1234, 1'b0, 12'h001, 12'h040, 16'h1234, 4'd6},
    {16'h0234, 1'b1, 12'h002, 12'h041, 16'hF000, 4'd6},
    {16'h0034, 1'b1, 12'h003, 12'h042, 16'h00FF, 4'd6},
    {16'h0034, 1'b1, 12'h004, 12'h043, 16'h0034, 4'd5},
    {16'h0034, 1'b1, 12'h006, 12'h044, 16'h0000, 4'd7},
    {16'h0034, 1'b1, 12'h007, 12'h045, 16'h0006, 4'd7},
    {16'hBEEF, 1'b1, 12'h008, 12'h047, 16'hBEEF, 4'd6},
    {16'h0000, 1'b1, 12'h009, 12'h048, 16'h4111, 4'd6},
    {16'h4111, 1'b0, 12'h00A, 12'h048, 16'h4111, 4'd6},
    {16'h4111, 1'b0, 12'h051, 12'h050, 16'h000B, 4'd6},
    {16'h4111, 1'b0, 12'h052, 12'h060, 16'h4111, 4'd5},
    {16'h4111, 1'b0, 12'h00B, 12'h050, 16'h000B, 4'd5},
    {16'h4111, 1'b0, 12'h00C, 12'h00B, 16'h7000, 4'd4},
    {16'h4111, 1'b0, 12'h00C, 12'h00C, 16'h400C, 4'd5}
  };

  function automatic string tag(int i);
    case (i)
      0, 2:     return "R5";
      1, 7, 8:  return "R6";
      3:        return "R7";
      4, 5:     return "R10";
      6, 10, 11: return "R12";
      9:        return "R9";
      12:       return "R11";
      default:  return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic ldw(logic [11:0] a, logic [15:0] dt);
    ld_we = 1'b1; ld_addr = a; ld_wdata = dt;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] s_ac;
    logic [11:0] s_pc;
    logic [2:0]  s_sc;
    logic        s_e;
    repeat (3) @(negedge clk);
    chk("R1 ac", ac, 16'h0);
    chk("R1 e", {15'b0, e}, 16'h0);
    chk("R1 pc", {4'b0, pc}, 16'h0);
    chk("R1 sc", {13'b0, sc}, 16'h0);
    chk("R1 done", {15'b0, done}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < 256; a++) ldw(12'(a), 16'h0000);
    ldw(12'h000, 16'h2040); ldw(12'h001, 16'h1041); ldw(12'h002, 16'h0042);
    ldw(12'h003, 16'h3043); ldw(12'h004, 16'h6044); ldw(12'h005, 16'h2040);
    ldw(12'h006, 16'h6045); ldw(12'h007, 16'hA046); ldw(12'h008, 16'h1048);
    ldw(12'h009, 16'h1048); ldw(12'h00A, 16'h5050); ldw(12'h00B, 16'h7000);
    ldw(12'h00C, 16'h400C); ldw(12'h051, 16'hB070); ldw(12'h052, 16'hC050);
    ldw(12'h040, 16'h1234); ldw(12'h041, 16'hF000); ldw(12'h042, 16'h00FF);
    ldw(12'h044, 16'hFFFF); ldw(12'h045, 16'h0005); ldw(12'h046, 16'h0047);
    ldw(12'h047, 16'hBEEF); ldw(12'h048, 16'h4111); ldw(12'h070, 16'h0060);
    rd_addr = 12'h040;
    chk("R2 load", rd_data, 16'h1234);

    run = 1'b1;
    for (int v = 0; v < 14; v++) begin
      int cyc;
      cyc = 0;
      forever begin
        cyc++;
        if (done || cyc > 20) break;
        @(negedge clk);
      end
      @(negedge clk);
      rd_addr = VEC[v][31:20];
      #1;
      chk({tag(v), " ac"}, ac, VEC[v][60:45]);
      chk({tag(v), " e"}, {15'b0, e}, {15'b0, VEC[v][44]});
      chk({"R4/", tag(v), " pc"}, {4'b0, pc}, {4'b0, VEC[v][43:32]});
      chk({tag(v), " mem"}, rd_data, VEC[v][19:4]);
      chk({"R13/", tag(v), " cycles"}, 16'(cyc), {12'b0, VEC[v][3:0]});
    end

    ld_we = 1'b1; ld_addr = 12'h090; ld_wdata = 16'h5555;
    repeat (3) @(negedge clk);
    ld_we = 1'b0;
    rd_addr = 12'h090;
    #1 chk("R2 ignored while running", rd_data, 16'h0000);

    run = 1'b0;
    s_ac = ac; s_pc = pc; s_sc = sc; s_e = e;
    repeat (5) @(negedge clk);
    chk("R3 sc hold", {13'b0, sc}, {13'b0, s_sc});
    chk("R3 pc hold", {4'b0, pc}, {4'b0, s_pc});
    chk("R3 ac hold", ac, s_ac);
    chk("R3 e hold", {15'b0, e}, {15'b0, s_e});

    ldw(12'h091, 16'hA5A5);
    rd_addr = 12'h091;
    #1 chk("R2 load while stopped", rd_data, 16'hA5A5);

    rst_n = 1'b0;
    #1;
    chk("R1 ac again", ac, 16'h0);
    chk("R1 pc again", {4'b0, pc}, 16'h0);
    chk("R1 sc again", {13'b0, sc}, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule